// File: doc/BRIEF.md
# Quadrature-Offset Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. A 32-bit step word is staged into an input register by a transfer strobe. A 32-bit accumulator then adds that staged step on every enabled system clock. The output frequency is step × f_clk / 2^32. A load strobe cuts the accumulator feedback, so the accumulator restarts from the staged step. This gives a known phase origin.

The top 13 accumulator bits are summed with a quadrant offset. The offset is picked by two modulation bits, which can be wired straight to the I/Q symbol bits of a QPSK modulator. The registered 13-bit result addresses a sine table. In that address, 0 means 0° and 0x1000 means 180°. The transfer, load and enable inputs are active low. They are registered before use, so each takes effect one clock after it is sampled. The modulation bits pass through two register stages before the offset adder.

Top module: `nco_phase_acc`

## Requirements
- R1: While rst_ni is low, the input register, the accumulator, the modulation delay line and phase_o are all zero.
- R2: When xfer_ni is sampled low, step_i from that edge is copied into the input register on the following edge. While xfer_ni stays high, step_i has no effect on the input register.
- R3: When load_ni is sampled low on one edge, the accumulator equals the input register after the next edge. phase_o reflects it one edge after that.
- R4: On each edge after acc_en_ni was sampled low, the accumulator adds the input register, modulo 2^32. A step of 0x20000000 repeats the phase every 8 clocks.
- R5: When acc_en_ni and load_ni are both sampled high, the accumulator holds its value.
- R6: When load_ni and acc_en_ni are sampled low together, the load wins. The accumulator takes the input register and does not add to its old value.
- R7: phase_o is the top 13 accumulator bits plus the quadrant offset, wrapped modulo 2^13.
- R8: The quadrant code quad_i maps to offsets as follows: 2'b00 → 0x0000 (0°), 2'b01 → 0x0800 (90°), 2'b11 → 0x1000 (180°), 2'b10 → 0x1800 (270°).
- R9: A change of quad_i sampled on one edge appears on phase_o after the third edge. It does not appear after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 32 | Selected frequency step word |
| xfer_ni | input | 1 | Transfer strobe into the input register, active low |
| load_ni | input | 1 | Accumulator load (feedback zeroed), active low |
| acc_en_ni | input | 1 | Accumulate enable, active low |
| quad_i | input | 2 | Quadrant modulation code |
| phase_o | output | 13 | Registered phase address |

## Verification
The bench drives step words whose top bits overflow when the offset is added. A design that did not wrap modulo 2^13 would show a wrong address. It applies all four quadrant codes, including the swapped 10 and 11 codes. A design with a monotonic mapping would put 180° and 270° the wrong way round. The bench sets load and enable together, where a design without load priority would add to the old phase. It counts exact enable pulses and watches the output at the edges where it must and must not change. A design that uses the controls without registering them, or with a modulation delay of the wrong depth, would show the new value one cycle early or late.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned PH_W   = 13;
  localparam int unsigned QUAD_W = 2;

  typedef enum logic [1:0] {
    QUAD_0   = 2'b00,
    QUAD_90  = 2'b01,
    QUAD_270 = 2'b10,
    QUAD_180 = 2'b11
  } quad_e;

  // quadrant code to offset in a PW-bit phase space (non-monotonic I/Q mapping)
  function automatic logic [PH_W-1:0] quad_offset(input logic [1:0] code);
    logic [PH_W-1:0] q;
    q = '0;
    unique case (quad_e'(code))
      QUAD_0:   q[PH_W-1 -: 2] = 2'd0;
      QUAD_90:  q[PH_W-1 -: 2] = 2'd1;
      QUAD_180: q[PH_W-1 -: 2] = 2'd2;
      QUAD_270: q[PH_W-1 -: 2] = 2'd3;
      default:  q = '0;
    endcase
    return q;
  endfunction
endpackage

// File: rtl/nco_ctrl_sync.sv
module nco_ctrl_sync #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] step_i,
  input  logic          xfer_ni,
  input  logic          load_ni,
  input  logic          acc_en_ni,
  output logic [AW-1:0] step_q_o,
  output logic          xfer_q_o,
  output logic          load_q_o,
  output logic          en_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q_o <= '0;
      xfer_q_o <= 1'b0;
      load_q_o <= 1'b0;
      en_q_o   <= 1'b0;
    end else begin
      step_q_o <= step_i;
      xfer_q_o <= ~xfer_ni;
      load_q_o <= ~load_ni;
      en_q_o   <= ~acc_en_ni;
    end
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] step_q_i,
  input  logic          xfer_q_i,
  input  logic          load_q_i,
  input  logic          en_q_i,
  output logic [AW-1:0] inreg_o,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       inreg_o <= '0;
    else if (xfer_q_i) inreg_o <= step_q_i;
  end

  // load zeroes feedback and overrides enable
  always_comb fb = load_q_i ? '0 : acc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acc_o <= '0;
    else if (load_q_i || en_q_i) acc_o <= fb + inreg_o;
  end
endmodule

// File: rtl/nco_quad_add.sv
module nco_quad_add
  import nco_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned PW   = 13,
  parameter int unsigned QDLY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] acc_i,
  input  logic [1:0]    quad_i,
  output logic [1:0]    quad_d_o,
  output logic [PW-1:0] phase_o
);
  logic [1:0] dly [QDLY+1];
  logic [PW-1:0] off;

  assign dly[0] = quad_i;

  for (genvar g = 0; g < QDLY; g++) begin : g_qdly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly[g+1] <= '0;
      else         dly[g+1] <= dly[g];
    end
  end

  assign quad_d_o = dly[QDLY];

  always_comb begin
    off = '0;
    off[PW-1 -: 2] = quad_offset(dly[QDLY])[PH_W-1 -: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= '0;
    else         phase_o <= acc_i[AW-1 -: PW] + off;
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int unsigned AW   = ACC_W,
  parameter int unsigned PW   = PH_W,
  parameter int unsigned QDLY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] step_i,
  input  logic          xfer_ni,
  input  logic          load_ni,
  input  logic          acc_en_ni,
  input  logic [1:0]    quad_i,
  output logic [PW-1:0] phase_o
);
  logic [AW-1:0] step_q, inreg, acc;
  logic          xfer_q, load_q, en_q;
  logic [1:0]    quad_d;

  nco_ctrl_sync #(.AW(AW)) u_sync (
    .clk_i, .rst_ni, .step_i, .xfer_ni, .load_ni, .acc_en_ni,
    .step_q_o(step_q), .xfer_q_o(xfer_q), .load_q_o(load_q), .en_q_o(en_q)
  );

  nco_accum #(.AW(AW)) u_acc (
    .clk_i, .rst_ni, .step_q_i(step_q), .xfer_q_i(xfer_q),
    .load_q_i(load_q), .en_q_i(en_q), .inreg_o(inreg), .acc_o(acc)
  );

  nco_quad_add #(.AW(AW), .PW(PW), .QDLY(QDLY)) u_quad (
    .clk_i, .rst_ni, .acc_i(acc), .quad_i, .quad_d_o(quad_d), .phase_o
  );
endmodule

// File: rtl/nco_phase_acc_chk.sv
module nco_phase_acc_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xfer_q,
  input logic          load_q,
  input logic          en_q,
  input logic [AW-1:0] inreg,
  input logic [AW-1:0] acc,
  input logic [1:0]    quad_d,
  input logic [PW-1:0] phase_o
);
  logic [PW-1:0] exp_off;
  always_comb begin
    exp_off = '0;
    case (quad_d)
      2'b01:   exp_off[PW-1 -: 2] = 2'd1;
      2'b11:   exp_off[PW-1 -: 2] = 2'd2;
      2'b10:   exp_off[PW-1 -: 2] = 2'd3;
      default: exp_off = '0;
    endcase
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i) !rst_ni |-> phase_o == '0); // R1
  AST_XFER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_q |=> $stable(inreg)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> acc == $past(inreg)); // R6
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !load_q) |=> acc == $past(acc) + $past(inreg)); // R4
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !load_q) |=> $stable(acc)); // R5
  AST_PHASE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == PW'($past(acc[AW-1 -: PW]) + $past(exp_off))); // R7
endmodule

bind nco_phase_acc nco_phase_acc_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk_i, .rst_ni, .xfer_q, .load_q, .en_q, .inreg, .acc, .quad_d, .phase_o
);

// File: tb/nco_phase_acc_test.sv
`timescale 1ns/1ps
module nco_phase_acc_test;
  logic        clk_i = 0, rst_ni = 0;
  logic [31:0] step_i = '0;
  logic        xfer_ni = 1, load_ni = 1, acc_en_ni = 1;
  logic [1:0]  quad_i = '0;
  logic [12:0] phase_o;
  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  nco_phase_acc uut (.*);

  typedef struct packed { logic [31:0] step; logic [1:0] quad; logic [12:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 2'b00, 13'h0000},
    '{32'h2000_0000, 2'b01, 13'h0C00},
    '{32'h8000_0000, 2'b11, 13'h0000},
    '{32'h1234_5678, 2'b10, 13'h1A46},
    '{32'hFFF8_0000, 2'b01, 13'h07FF},
    '{32'h0008_0000, 2'b00, 13'h0001}
  };

  task automatic check(input string req, input logic [12:0] exp);
    n_run++;
    if (phase_o !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_o=%h expected=%h", req, phase_o, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic xfer(input logic [31:0] s);
    step_i = s; xfer_ni = 0; cyc(1); xfer_ni = 1; cyc(1);
  endtask

  // load pulse; phase_o valid after return
  task automatic load_now();
    load_ni = 0; cyc(1); load_ni = 1; cyc(2);
  endtask

  task automatic run_en(input int n);
    acc_en_ni = 0; cyc(n); acc_en_ni = 1; cyc(2);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    check("R1 reset", 13'h0000);
    rst_ni = 1; cyc(2);

    // table: stage, load, set quadrant
    for (int k = 0; k < 6; k++) begin
      xfer(VECS[k].step);
      load_now();
      quad_i = VECS[k].quad;
      cyc(4);
      check("R7/R8 table", VECS[k].exp);
    end

    // R8: remaining mapping, acc top = 0x0001
    quad_i = 2'b11; cyc(4); check("R8 code11", 13'h1001);
    quad_i = 2'b10; cyc(4); check("R8 code10", 13'h1801);

    // R9: quadrant latency
    quad_i = 2'b00; cyc(4); check("R9 base", 13'h0001);
    quad_i = 2'b01; cyc(2); check("R9 not yet", 13'h0001);
    cyc(1); check("R9 third edge", 13'h0801);
    quad_i = 2'b00; cyc(4);

    // R2: step_i without strobe ignored
    step_i = 32'h4000_0000; cyc(2);
    load_now(); check("R2 no strobe", 13'h0001);
    xfer(32'h2000_0000); load_now(); check("R2/R3 strobe", 13'h0400);

    // R5: hold
    cyc(6); check("R5 hold", 13'h0400);

    // R4: 3 enables -> 4*S = 0x80000000
    run_en(3); check("R4 three steps", 13'h1000);
    run_en(4); check("R4 wrap", 13'h0000);
    run_en(4); check("R4 period 8", 13'h1000);
    run_en(1); check("R4 single pulse", 13'h1400);

    // R6: load with enable, acc currently 0xA0000000
    load_ni = 0; acc_en_ni = 0; cyc(1); load_ni = 1; acc_en_ni = 1; cyc(2);
    check("R6 load priority", 13'h0400);

    // R1: async reset mid-run
    run_en(2); rst_ni = 0; #1; check("R1 async", 13'h0000);
    cyc(2); rst_ni = 1; cyc(3); check("R1 after release", 13'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule